// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Section

This block is one slice of a bus transceiver that joins an A port and a B port. Each side has its own storage register, capture clock and source select. The value sent toward B is either the live A input or the word last stored from A. The value sent toward A is either the live B input or the word last stored from B. The data width is a parameter, with a default of 9. A wider transceiver uses several independent copies of this section, and each copy has its own control inputs.

Each port is modelled as a separate input vector, output vector and per-bit output-enable vector, so no tri-state pads are needed. One active-low output enable and one direction input decide which side drives. With the output enable high, both sides are released. With it low, the direction input picks the side that drives. Each register captures on every rising edge of its own clock, whatever the state of the enables. This lets the block store data from A, from B or from both while the buses stay isolated. A test-hold input forces both sides off and freezes both registers. The registers clear asynchronously on `rst_ni`.

Top module: `xcvr_section`

## Requirements
- R1: After `rst_ni` is released, both storage registers hold zero. With a select high, the corresponding data output reads 0.
- R2: While `oe_ni` is 1, `a_oe_o` and `b_oe_o` are all zeros, for either value of `dir_i`.
- R3: While `oe_ni` is 0, `test_hold_i` is 0 and `dir_i` is 1, `b_oe_o` is all ones and `a_oe_o` is all zeros.
- R4: While `oe_ni` is 0, `test_hold_i` is 0 and `dir_i` is 0, `a_oe_o` is all ones and `b_oe_o` is all zeros.
- R5: With `sel_ab_i` at 0, `b_o` equals `a_i` combinationally, with no clock edge needed. With `sel_ba_i` at 0, `a_o` equals `b_i` in the same way.
- R6: With `sel_ab_i` at 1, `b_o` equals the `a_i` value sampled at the last rising edge of `clk_ab_i`. Later changes of `a_i` have no effect on `b_o`.
- R7: With `sel_ba_i` at 1, `a_o` equals the `b_i` value sampled at the last rising edge of `clk_ba_i`. Later changes of `b_i` have no effect on `a_o`.
- R8: Captures take place while `oe_ni` is 1 and for either value of `dir_i`. Words stored while isolated are read back later through the data outputs.
- R9: A rising edge of `clk_ab_i` leaves the B-side register unchanged, and a rising edge of `clk_ba_i` leaves the A-side register unchanged.
- R10: While `test_hold_i` is 1, both enable vectors are all zeros, even with `oe_ni` at 0.
- R11: While `test_hold_i` is 1, rising clock edges do not change either register.
- R12: The data outputs present their selected source whatever the value of the enables. `a_oe_o` and `b_oe_o` are never both nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock for the A-side register (rising edge) |
| clk_ba_i | input | 1 | Capture clock for the B-side register (rising edge) |
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| test_hold_i | input | 1 | Forces enables off and freezes both registers |
| oe_ni | input | 1 | Active-low shared output enable |
| dir_i | input | 1 | 1: B side driven from A; 0: A side driven from B |
| sel_ab_i | input | 1 | Source toward B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source toward A: 0 live B, 1 stored B |
| a_i | input | WIDTH | A bus input word |
| b_i | input | WIDTH | B bus input word |
| a_o | output | WIDTH | Word presented to the A bus |
| a_oe_o | output | WIDTH | Per-bit drive enable for the A bus |
| b_o | output | WIDTH | Word presented to the B bus |
| b_oe_o | output | WIDTH | Per-bit drive enable for the B bus |

## Verification
The data paths are tried with distinct words on the two sides, such as 0x155 against 0x0AA. A read that comes back from the wrong register or the wrong live input therefore shows up at once. In each registered mode the live input is changed after the capture edge, which separates a stored path from a transparent one. Clock pulses go to one side alone, with the words on the other side fixed, to show that the two registers are independent. Storage while isolated and storage under test hold are both read back through the data outputs. They distinguish "captures regardless of enables" from "captures gated by the hold".

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  typedef enum logic {
    DRV_TO_A = 1'b0,
    DRV_TO_B = 1'b1
  } drv_dir_e;
endpackage

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_src_mux.sv
`timescale 1ns/1ps
module xcvr_src_mux #(
  parameter int WIDTH = 9
) (
  input  xcvr_pkg::src_sel_e sel_i,
  input  logic [WIDTH-1:0]   live_i,
  input  logic [WIDTH-1:0]   stored_i,
  output logic [WIDTH-1:0]   y_o
);
  always_comb begin
    unique case (sel_i)
      xcvr_pkg::SRC_STORED: y_o = stored_i;
      default:              y_o = live_i;
    endcase
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
`timescale 1ns/1ps
module xcvr_drive_ctl #(
  parameter int WIDTH = 9
) (
  input  logic               oe_ni,
  input  logic               hold_i,
  input  xcvr_pkg::drv_dir_e dir_i,
  output logic [WIDTH-1:0]   a_oe_o,
  output logic [WIDTH-1:0]   b_oe_o
);
  logic active;
  logic drv_a, drv_b;

  assign active = !oe_ni && !hold_i;
  assign drv_b  = active && (dir_i == xcvr_pkg::DRV_TO_B);
  assign drv_a  = active && (dir_i == xcvr_pkg::DRV_TO_A);

  // one enable per pad bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad_en
    assign a_oe_o[i] = drv_a;
    assign b_oe_o[i] = drv_b;
  end
endmodule

// File: rtl/xcvr_section.sv
`timescale 1ns/1ps
module xcvr_section #(
  parameter int WIDTH = 9
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             test_hold_i,
  input  logic             oe_ni,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] reg_a_q, reg_b_q;

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk_i (clk_ab_i),
    .rst_ni(rst_ni),
    .hold_i(test_hold_i),
    .d_i   (a_i),
    .q_o   (reg_a_q)
  );

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk_i (clk_ba_i),
    .rst_ni(rst_ni),
    .hold_i(test_hold_i),
    .d_i   (b_i),
    .q_o   (reg_b_q)
  );

  xcvr_src_mux #(.WIDTH(WIDTH)) u_mux_to_b (
    .sel_i   (src_sel_e'(sel_ab_i)),
    .live_i  (a_i),
    .stored_i(reg_a_q),
    .y_o     (b_o)
  );

  xcvr_src_mux #(.WIDTH(WIDTH)) u_mux_to_a (
    .sel_i   (src_sel_e'(sel_ba_i)),
    .live_i  (b_i),
    .stored_i(reg_b_q),
    .y_o     (a_o)
  );

  xcvr_drive_ctl #(.WIDTH(WIDTH)) u_drv (
    .oe_ni (oe_ni),
    .hold_i(test_hold_i),
    .dir_i (drv_dir_e'(dir_i)),
    .a_oe_o(a_oe_o),
    .b_oe_o(b_oe_o)
  );
endmodule

// File: rtl/xcvr_section_chk.sv
`timescale 1ns/1ps
module xcvr_section_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             rst_ni,
  input logic             test_hold_i,
  input logic             oe_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] a_oe_o,
  input logic [WIDTH-1:0] b_oe_o,
  input logic [WIDTH-1:0] reg_a_q,
  input logic [WIDTH-1:0] reg_b_q
);
  assert_isolate_R2: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    oe_ni |-> (a_oe_o == '0 && b_oe_o == '0));

  assert_one_side_R12: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));

  assert_hold_off_R10: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    test_hold_i |-> (a_oe_o == '0 && b_oe_o == '0));

  assert_cap_a_R6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !test_hold_i |=> reg_a_q == $past(a_i));

  assert_cap_b_R7: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !test_hold_i |=> reg_b_q == $past(b_i));

  assert_freeze_a_R11: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    test_hold_i |=> $stable(reg_a_q));

  assert_freeze_b_R11: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    test_hold_i |=> $stable(reg_b_q));
endmodule

bind xcvr_section xcvr_section_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_ab_i   (clk_ab_i),
  .clk_ba_i   (clk_ba_i),
  .rst_ni     (rst_ni),
  .test_hold_i(test_hold_i),
  .oe_ni      (oe_ni),
  .a_i        (a_i),
  .b_i        (b_i),
  .a_oe_o     (a_oe_o),
  .b_oe_o     (b_oe_o),
  .reg_a_q    (reg_a_q),
  .reg_b_q    (reg_b_q)
);

// File: tb/xcvr_section_test.sv
`timescale 1ns/1ps
module xcvr_section_test;
  localparam int W = 9;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic ab_en = 1'b0, ba_en = 1'b0;
  logic rst_ni = 1'b0, test_hold_i = 1'b0, oe_ni = 1'b1, dir_i = 1'b0;
  logic sel_ab_i = 1'b0, sel_ba_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, a_oe_o, b_o, b_oe_o;
  logic clk_ab_i, clk_ba_i;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  // enables change only while clk is low, so the gated clocks stay clean
  assign clk_ab_i = clk & ab_en;
  assign clk_ba_i = clk & ba_en;

  xcvr_section #(.WIDTH(W)) uut (
    .clk_ab_i, .clk_ba_i, .rst_ni, .test_hold_i, .oe_ni, .dir_i,
    .sel_ab_i, .sel_ba_i, .a_i, .b_i, .a_o, .a_oe_o, .b_o, .b_oe_o
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(bit ab, bit ba);
    @(negedge clk); ab_en = ab; ba_en = ba;
    @(negedge clk); ab_en = 1'b0; ba_en = 1'b0;
    #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    sel_ab_i = 1; sel_ba_i = 1; oe_ni = 0; dir_i = 1;
    a_i = 9'h1FF; b_i = 9'h1FF;
    settle();
    check("R1 b_o", b_o, '0);
    check("R1 a_o", a_o, '0);
  endtask

  task automatic t_isolate();
    oe_ni = 1; dir_i = 1; settle();
    check("R2 a_oe dir1", a_oe_o, '0);
    check("R2 b_oe dir1", b_oe_o, '0);
    dir_i = 0; settle();
    check("R2 a_oe dir0", a_oe_o, '0);
    check("R2 b_oe dir0", b_oe_o, '0);
  endtask

  task automatic t_direction();
    oe_ni = 0; dir_i = 1; settle();
    check("R3 b_oe", b_oe_o, ONES);
    check("R3 a_oe", a_oe_o, '0);
    dir_i = 0; settle();
    check("R4 a_oe", a_oe_o, ONES);
    check("R4 b_oe", b_oe_o, '0);
  endtask

  task automatic t_live();
    sel_ab_i = 0; sel_ba_i = 0; oe_ni = 1;
    a_i = 9'h155; b_i = 9'h0AA; settle();
    check("R5 b_o live", b_o, 9'h155);
    check("R5 a_o live", a_o, 9'h0AA);
    a_i = 9'h03C; settle();
    check("R5 b_o follows", b_o, 9'h03C);
    check("R12 a_o with enables off", a_o, 9'h0AA);
  endtask

  task automatic t_stored_ab();
    oe_ni = 0; dir_i = 1; sel_ab_i = 1;
    a_i = 9'h123; pulse(1, 0);
    a_i = 9'h0F0; settle();
    check("R6 b_o stored", b_o, 9'h123);
  endtask

  task automatic t_stored_ba();
    oe_ni = 0; dir_i = 0; sel_ba_i = 1;
    b_i = 9'h0DE; pulse(0, 1);
    b_i = 9'h111; settle();
    check("R7 a_o stored", a_o, 9'h0DE);
  endtask

  task automatic t_store_isolated();
    oe_ni = 1; dir_i = 0;
    a_i = 9'h1A5; b_i = 9'h05A; pulse(1, 1);
    a_i = 9'h000; b_i = 9'h000;
    oe_ni = 0; sel_ab_i = 1; sel_ba_i = 1; settle();
    check("R8 A stored while isolated", b_o, 9'h1A5);
    check("R8 B stored while isolated", a_o, 9'h05A);
  endtask

  task automatic t_independent();
    sel_ab_i = 1; sel_ba_i = 1;
    a_i = 9'h0C3; b_i = 9'h13C; pulse(1, 0);
    check("R9 B reg kept on A clock", a_o, 9'h05A);
    check("R9 A reg loaded", b_o, 9'h0C3);
    a_i = 9'h077; b_i = 9'h188; pulse(0, 1);
    check("R9 A reg kept on B clock", b_o, 9'h0C3);
    check("R9 B reg loaded", a_o, 9'h188);
  endtask

  task automatic t_test_hold();
    oe_ni = 0; dir_i = 1; test_hold_i = 1; settle();
    check("R10 b_oe off", b_oe_o, '0);
    check("R10 a_oe off", a_oe_o, '0);
    a_i = 9'h1E1; b_i = 9'h01E; pulse(1, 1);
    check("R11 A frozen", b_o, 9'h0C3);
    check("R11 B frozen", a_o, 9'h188);
    test_hold_i = 0; settle();
    check("R3 enables back after hold", b_oe_o, ONES);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_isolate();
    t_direction();
    t_live();
    t_stored_ab();
    t_stored_ba();
    t_store_isolated();
    t_independent();
    t_test_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule